// File: doc/BRIEF.md
# Extinction Angle Monitor

This block watches the six valves of a line-commutated bridge and measures, for each one, how far the electrical phase has advanced since that valve stopped conducting. A phase tracker supplies a synchronised angle word on every clock, which is one sample step. Each valve has three event inputs: a strobe marking its current zero, a level saying its voltage is positive, and a strobe marking a fresh conduction start.

A current-zero strobe opens a measurement window for that valve. The window stays open while the valve is reverse-blocking. When the valve's voltage turns positive, the window closes and the block reports the angle it accumulated, together with the valve index. It also raises a single-cycle valid strobe. If the angle is below a programmable minimum, or if the valve starts conducting again before its voltage turns positive, the block sets a sticky commutation-failure flag. A typical minimum is 80 to 115 counts, which is 7 to 10 degrees. The flag stays set until a clear pulse arrives. The regulator that consumes the angle sits downstream and is not part of this block.

Angles use 4096 counts per turn. Elapsed angles wrap modulo 4096 and saturate at 2048 counts, which is half a turn.

Top module: `xangle_watch`

## Requirements
- R1: After reset, `vld`, `fail`, `gamma` and `gidx` are all 0, and no window is open.
- R2: A `zc` strobe on bit i opens valve i's window and captures `phase`. If the window is already open, the strobe restarts it from the new phase.
- R3: When `vpos[i]` is high in a cycle where valve i's window is open, `vld` is 1 for exactly one cycle on the next cycle. In that cycle `gamma` = (phase at that cycle − captured phase) mod 4096, and `gidx` = i. The window then closes, so a later `vpos[i]` produces no `vld`.
- R4: The elapsed angle saturates at 2048. Once 2048 has been reached during a window, the reported angle stays 2048, even if the phase difference later becomes smaller.
- R5: A closing window whose angle is strictly below `min_angle` sets `fail` on the same cycle as `vld`. An angle equal to `min_angle` does not set it.
- R6: `cond[i]` high while valve i's window is open sets `fail`. It also closes the window without a `vld` pulse, and `cond` takes priority over `vpos` in the same cycle.
- R7: `fail` stays set until `clr` is pulsed. A new failure in the same cycle as `clr` leaves `fail` set.
- R8: `vpos[i]` and `cond[i]` have no effect while valve i has no open window.
- R9: If several windows close in the same cycle, the lowest valve index is reported. All of those windows close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each cycle is one sample step |
| rst_n | input | 1 | Active-low synchronous reset |
| phase | input | 12 | Synchronised phase angle, 4096 counts per turn |
| zc | input | 6 | Per-valve current-zero strobes |
| vpos | input | 6 | Per-valve positive-voltage level |
| cond | input | 6 | Per-valve conduction-start strobes |
| min_angle | input | 12 | Failure threshold in counts |
| clr | input | 1 | Clears the failure flag |
| gamma | output | 12 | Angle of the most recently closed window |
| gidx | output | 3 | Valve index belonging to `gamma` |
| fail | output | 1 | Sticky commutation-failure flag |
| vld | output | 1 | One-cycle strobe for a new `gamma` |

## Verification
The bench builds the block with its default six valves and 12-bit angles, and holds the threshold at 91 counts. With those values it sweeps every valve across elapsed angles that sit on both sides of the threshold and of the half-turn cap. It also starts from phases just below the wrap point, so that the modulo-4096 subtraction is exercised. Saturation that must hold through a falling phase difference, early re-conduction, simultaneous closes, restarts and clear-versus-set collisions are each driven as dedicated sequences.

// File: rtl/xangle_watch.sv
module xangle_watch #(
  parameter int NV = 6,
  parameter int AW = 12,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] phase,
  input  logic [NV-1:0] zc,
  input  logic [NV-1:0] vpos,
  input  logic [NV-1:0] cond,
  input  logic [AW-1:0] min_angle,
  input  logic          clr,
  output logic [AW-1:0] gamma,
  output logic [IW-1:0] gidx,
  output logic          fail,
  output logic          vld
);
  localparam logic [AW-1:0] SAT = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] start_q [NV];
  logic [AW-1:0] elap_q  [NV];
  logic [AW-1:0] cur     [NV];
  logic [NV-1:0] open_q, close_v, short_v, low_v;

  for (genvar g = 0; g < NV; g++) begin : g_valve
    logic [AW-1:0] diff;
    assign diff       = phase - start_q[g];
    assign cur[g]     = (elap_q[g] == SAT || diff >= SAT) ? SAT : diff;
    assign short_v[g] = open_q[g] & cond[g] & ~zc[g];
    assign close_v[g] = open_q[g] & vpos[g] & ~cond[g] & ~zc[g];
    assign low_v[g]   = close_v[g] & (cur[g] < min_angle);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_q[g]  <= 1'b0;
        start_q[g] <= '0;
        elap_q[g]  <= '0;
      end else if (zc[g]) begin
        open_q[g]  <= 1'b1;
        start_q[g] <= phase;
        elap_q[g]  <= '0;
      end else if (open_q[g]) begin
        elap_q[g] <= cur[g];
        if (vpos[g] || cond[g]) open_q[g] <= 1'b0;
      end
    end
  end

  logic          hit;
  logic [IW-1:0] sel;
  logic [AW-1:0] sel_ang;

  always_comb begin
    hit     = |close_v;
    sel     = '0;
    sel_ang = '0;
    for (int i = NV - 1; i >= 0; i--) begin
      if (close_v[i]) begin
        sel     = IW'(i);
        sel_ang = cur[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gamma <= '0;
      gidx  <= '0;
      vld   <= 1'b0;
      fail  <= 1'b0;
    end else begin
      vld <= hit;
      if (hit) begin
        gamma <= sel_ang;
        gidx  <= sel;
      end
      if (|short_v || |low_v) fail <= 1'b1;
      else if (clr)           fail <= 1'b0;
    end
  end
endmodule

// File: rtl/xangle_watch_chk.sv
module xangle_watch_chk #(
  parameter int NV = 6,
  parameter int AW = 12,
  localparam int IW = (NV > 1) ? $clog2(NV) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic [AW-1:0] min_angle,
  input logic [AW-1:0] gamma,
  input logic [IW-1:0] gidx,
  input logic          fail,
  input logic          vld
);
  localparam int SATI = 1 << (AW - 1);

  a_r4_gamma_cap: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (int'(gamma) <= SATI));

  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (int'(gidx) < NV));

  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clr) |=> fail);

  // R5: threshold held constant by the user of this check
  a_r5_low_sets_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && gamma < min_angle) |-> fail);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fail) |-> $past(clr));
endmodule

bind xangle_watch xangle_watch_chk #(.NV(NV), .AW(AW)) chk_i (.*);

// File: tb/xangle_watch_tb.sv
module xangle_watch_tb_top;
  localparam int CLK_P = 10;
  localparam int NV = 6;
  localparam int MIN = 91;

  logic clk = 0, rst_n = 0, clr = 0;
  logic [11:0] phase = 0, min_angle = 12'(MIN);
  logic [NV-1:0] zc = 0, vpos = 0, cond = 0;
  logic [11:0] gamma;
  logic [2:0] gidx;
  logic fail, vld;
  int checks = 0, errs = 0;

  always #(CLK_P/2) clk = ~clk;

  xangle_watch dut_i (.clk, .rst_n, .phase, .zc, .vpos, .cond, .min_angle, .clr,
                      .gamma, .gidx, .fail, .vld);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_fail();
    clr = 1; @(negedge clk); clr = 0;
    chk("R7 cleared", fail, 0);
  endtask

  task automatic meas(input int v, input int p1, input int d);
    int m = d % 4096;
    int e = (m >= 2048) ? 2048 : m;
    @(negedge clk); phase = 12'(p1); zc = NV'(1) << v;
    @(negedge clk); zc = 0; phase = 12'(p1 + d);
    @(negedge clk); vpos = NV'(1) << v;
    @(negedge clk); vpos = 0;
    chk("R3 vld", vld, 1);
    chk("R3 gamma", gamma, e);
    chk("R3 gidx", gidx, v);
    chk("R5 fail", fail, (e < MIN) ? 1 : 0);
    vpos = NV'(1) << v;
    @(negedge clk); vpos = 0;
    chk("R3 single pulse / closed", vld, 0);
    chk("R7 held", fail, (e < MIN) ? 1 : 0);
    clear_fail();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    int ds[8] = '{0, 1, 90, 91, 92, 2047, 2048, 4095};
    int ps[2] = '{100, 4090};
    repeat (3) @(negedge clk);
    chk("R1 vld", vld, 0); chk("R1 fail", fail, 0);
    chk("R1 gamma", gamma, 0); chk("R1 gidx", gidx, 0);
    rst_n = 1;
    // R8 before any window
    vpos = '1; cond = '1; @(negedge clk); vpos = 0; cond = 0;
    chk("R8 idle vld", vld, 0); chk("R8 idle fail", fail, 0);

    for (int v = 0; v < NV; v++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 8; k++) meas(v, ps[p], ds[k]);

    // R4 sticky saturation
    @(negedge clk); phase = 12'd500; zc = 6'b000100;
    @(negedge clk); zc = 0; phase = 12'(500 + 2100);
    @(negedge clk); phase = 12'(500 + 100);
    @(negedge clk); vpos = 6'b000100;
    @(negedge clk); vpos = 0;
    chk("R4 sticky sat", gamma, 2048); chk("R4 vld", vld, 1);

    // R2 restart
    @(negedge clk); phase = 12'd100; zc = 6'b010000;
    @(negedge clk); zc = 0; phase = 12'd300;
    @(negedge clk); zc = 6'b010000;
    @(negedge clk); zc = 0; phase = 12'd450;
    @(negedge clk); vpos = 6'b010000;
    @(negedge clk); vpos = 0;
    chk("R2 restart gamma", gamma, 150); chk("R2 gidx", gidx, 4);

    // R6 re-conduction
    @(negedge clk); phase = 12'd1000; zc = 6'b000010;
    @(negedge clk); zc = 0; phase = 12'd1600;
    @(negedge clk); cond = 6'b000010; vpos = 6'b000010;
    @(negedge clk); cond = 0; vpos = 0;
    chk("R6 fail", fail, 1); chk("R6 no vld", vld, 0);
    vpos = 6'b000010;
    @(negedge clk); vpos = 0;
    chk("R6 window closed", vld, 0);
    clear_fail();

    // R7 set wins over clear
    @(negedge clk); phase = 12'd0; zc = 6'b100000;
    @(negedge clk); zc = 0; cond = 6'b100000; clr = 1;
    @(negedge clk); cond = 0; clr = 0;
    chk("R7 set beats clear", fail, 1);
    clear_fail();

    // R9 simultaneous closes
    @(negedge clk); phase = 12'd200; zc = 6'b010010;
    @(negedge clk); zc = 0; phase = 12'd700;
    @(negedge clk); vpos = 6'b010010;
    @(negedge clk); vpos = 0;
    chk("R9 vld", vld, 1); chk("R9 gidx", gidx, 1); chk("R9 gamma", gamma, 500);
    vpos = 6'b010000;
    @(negedge clk); vpos = 0;
    chk("R9 both closed", vld, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule